// File: doc/BRIEF.md
# Reservation Monitor for Linked Load / Conditional Store

This block sits beside a cache controller and watches the stream of completed memory requests. A linked load places a reservation on its cache line, tagged with the requester that issued it. A later conditional store by that same requester succeeds only while the reservation is still in place. Any conditional store removes the line's reservation. An ordinary write to a line that is present and reserved by the writer also removes it. Loads and instruction fetches pass through without effect.

The monitor also handles locked read-modify-write pairs. The read half tells the line's request queue to hold further requests, and the write half releases it. A configuration input bypasses the reservation logic: in that mode every completion reports success and the reservation registers do not change. The block holds a small parameterised set of reservation registers. Each register has a valid bit, a line address and an owner ID. When every register is in use, a new reservation replaces the least recently written one. All results are registered and appear one cycle after the completion.

Top module: `llsc_resv_monitor`

## Requirements
- R1: A linked load (kind 3) reports success and leaves a valid reservation whose line and owner equal the completion's line and requester ID.
- R2: A linked load to a line that already holds a reservation rewrites that register's owner in place, and no second register for the line appears.
- R3: A linked load to an unreserved line takes the lowest-numbered free register. If no register is free, it replaces the register written least recently, where an in-place rewrite counts as a write.
- R4: A conditional store (kind 4) reports success (ok = 1) only when a valid reservation exists with the same line and the same owner. Otherwise it reports ok = 0.
- R5: Every conditional store removes the reservation on its line, whether it succeeds or fails.
- R6: A plain store (kind 2), atomic (kind 7), locked read (kind 5) or locked write (kind 6) reports ok = 1. It removes the line's reservation only when the tag-present input is 1 and the reservation's owner equals the requester. Otherwise the reservation remains.
- R7: A load (kind 0) or fetch (kind 1) reports ok = 1 and leaves all reservations unchanged.
- R8: A locked read (kind 5) produces a one-cycle block pulse, and a locked write (kind 6) produces a one-cycle unblock pulse. Each pulse carries the completion's line on the command line output. The two pulses never occur together, and both are produced whether or not bypass is set.
- R9: While bypass is 1, every completion reports ok = 1 and the reservation registers do not change.
- R10: The done, ok, block and unblock outputs are registered and reflect the completion presented one cycle earlier. With no completion they are all 0.
- R11: After reset, no reservation is valid and the done, ok, block and unblock outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass_i | input | 1 | 1 = reservation logic bypassed |
| cpl_valid_i | input | 1 | A completion is presented this cycle |
| cpl_kind_i | input | 3 | Request kind: 0 load, 1 fetch, 2 store, 3 linked load, 4 conditional store, 5 locked read, 6 locked write, 7 atomic |
| cpl_line_i | input | LINE_W | Line address of the completion |
| cpl_req_id_i | input | ID_W | Requester ID |
| cpl_tag_hit_i | input | 1 | Line is present in the cache |
| rsp_done_o | output | 1 | Result valid, one cycle after the completion |
| rsp_ok_o | output | 1 | Success bit |
| blk_o | output | 1 | Block pulse for the line's request queue |
| unblk_o | output | 1 | Unblock pulse for the line's request queue |
| cmd_line_o | output | LINE_W | Line address of the last block or unblock command |
| resv_valid_o | output | NUM_RESV | Valid bit of each reservation register |
| resv_line_o | output | NUM_RESV*LINE_W | Line of each register, register i in slice i |
| resv_owner_o | output | NUM_RESV*ID_W | Owner of each register, register i in slice i |

## Verification
Two functions can fall in the same cycle: a locked write that releases the queue block, and the owner-matched removal of that line's reservation. The bench provokes this by reserving a line and then completing a locked write to it from the owner with the tag present. In the following cycle it requires both the unblock pulse and the absence of the reservation. Victim choice is judged through the per-register line outputs. The bench uses a fill, a replacement, an age-refreshing rewrite, a second replacement and a reuse of a freed register, with the expected slot worked out by hand from the write order.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    K_LOAD     = 3'd0,
    K_FETCH    = 3'd1,
    K_STORE    = 3'd2,
    K_LL       = 3'd3,
    K_SC       = 3'd4,
    K_LRMW_RD  = 3'd5,
    K_LRMW_WR  = 3'd6,
    K_ATOMIC   = 3'd7
  } cpl_kind_e;

  // Kinds that count as writes for reservation purposes.
  function automatic logic is_write_kind(cpl_kind_e k);
    return (k == K_STORE) || (k == K_LL) || (k == K_SC) ||
           (k == K_LRMW_RD) || (k == K_LRMW_WR) || (k == K_ATOMIC);
  endfunction

  // Writes other than the linked pair: they may only drop an owned reservation.
  function automatic logic is_plain_write(cpl_kind_e k);
    return is_write_kind(k) && (k != K_LL) && (k != K_SC);
  endfunction

  // Success bit: only an active conditional store can fail.
  function automatic logic calc_ok(cpl_kind_e k, logic bypass, logic owner_match);
    if (bypass)      return 1'b1;
    if (k == K_SC)   return owner_match;
    return 1'b1;
  endfunction

endpackage

// File: rtl/resv_match.sv
module resv_match #(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              ent_valid [N],
  input  logic [LINE_W-1:0] ent_line  [N],
  input  logic [ID_W-1:0]   ent_owner [N],
  input  logic [LINE_W-1:0] q_line,
  input  logic [ID_W-1:0]   q_id,
  output logic [N-1:0]      line_hit,
  output logic [N-1:0]      own_hit,
  output logic              any_line_hit,
  output logic              any_own_hit
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign line_hit[g] = ent_valid[g] && (ent_line[g] == q_line);
    assign own_hit[g]  = line_hit[g] && (ent_owner[g] == q_id);
  end

  assign any_line_hit = |line_hit;
  assign any_own_hit  = |own_hit;

endmodule

// File: rtl/resv_victim.sv
module resv_victim #(
  parameter int N     = 4,
  parameter int AGE_W = 2
) (
  input  logic             ent_valid [N],
  input  logic [AGE_W-1:0] ent_age   [N],
  input  logic [N-1:0]     line_hit,
  output logic [N-1:0]     tgt_sel
);

  logic             free_found;
  logic [N-1:0]     free_sel;
  logic [N-1:0]     old_sel;
  logic [AGE_W-1:0] best_age;

  // Lowest-numbered free register.
  always_comb begin
    free_sel   = '0;
    free_found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!free_found && !ent_valid[i]) begin
        free_sel[i] = 1'b1;
        free_found  = 1'b1;
      end
    end
  end

  // Register with the greatest age (least recently written).
  always_comb begin
    old_sel  = '0;
    old_sel[0] = 1'b1;
    best_age = ent_age[0];
    for (int i = 1; i < N; i++) begin
      if (ent_age[i] > best_age) begin
        best_age = ent_age[i];
        old_sel  = '0;
        old_sel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (|line_hit)       tgt_sel = line_hit;
    else if (free_found) tgt_sel = free_sel;
    else                 tgt_sel = old_sel;
  end

endmodule

// File: rtl/resv_store.sv
module resv_store #(
  parameter int N      = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 4,
  parameter int AGE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [N-1:0]      wr_sel,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [ID_W-1:0]   wr_owner,
  input  logic              clr_en,
  input  logic [N-1:0]      clr_sel,
  output logic              ent_valid [N],
  output logic [LINE_W-1:0] ent_line  [N],
  output logic [ID_W-1:0]   ent_owner [N],
  output logic [AGE_W-1:0]  ent_age   [N]
);

  // Ages of valid registers are kept dense: 0 .. count-1, 0 = newest.
  logic             sel_was_valid;
  logic [AGE_W-1:0] sel_age;
  logic [AGE_W-1:0] clr_age;

  always_comb begin
    sel_was_valid = 1'b0;
    sel_age       = '0;
    clr_age       = '0;
    for (int i = 0; i < N; i++) begin
      if (wr_sel[i]) begin
        sel_was_valid = sel_was_valid | ent_valid[i];
        sel_age       = sel_age | ent_age[i];
      end
      if (clr_sel[i]) clr_age = clr_age | ent_age[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ent_valid[i] <= 1'b0;
        ent_line[i]  <= '0;
        ent_owner[i] <= '0;
        ent_age[i]   <= '0;
      end
    end else if (wr_en) begin
      for (int i = 0; i < N; i++) begin
        if (wr_sel[i]) begin
          ent_valid[i] <= 1'b1;
          ent_line[i]  <= wr_line;
          ent_owner[i] <= wr_owner;
          ent_age[i]   <= '0;
        end else if (ent_valid[i] && (!sel_was_valid || (ent_age[i] < sel_age))) begin
          ent_age[i] <= ent_age[i] + AGE_W'(1);
        end
      end
    end else if (clr_en) begin
      for (int i = 0; i < N; i++) begin
        if (clr_sel[i]) begin
          ent_valid[i] <= 1'b0;
        end else if (ent_valid[i] && (ent_age[i] > clr_age)) begin
          ent_age[i] <= ent_age[i] - AGE_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/resp_stage.sv
module resp_stage #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_done,
  input  logic              in_ok,
  input  logic              in_blk,
  input  logic              in_unblk,
  input  logic [LINE_W-1:0] in_line,
  output logic              done_q,
  output logic              ok_q,
  output logic              blk_q,
  output logic              unblk_q,
  output logic [LINE_W-1:0] line_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
      line_q  <= '0;
    end else begin
      done_q  <= in_done;
      ok_q    <= in_done && in_ok;
      blk_q   <= in_blk;
      unblk_q <= in_unblk;
      if (in_blk || in_unblk) line_q <= in_line;
    end
  end

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int NUM_RESV = 4,
  parameter int LINE_W   = 26,
  parameter int ID_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bypass_i,
  input  logic                       cpl_valid_i,
  input  logic [2:0]                 cpl_kind_i,
  input  logic [LINE_W-1:0]          cpl_line_i,
  input  logic [ID_W-1:0]            cpl_req_id_i,
  input  logic                       cpl_tag_hit_i,
  output logic                       rsp_done_o,
  output logic                       rsp_ok_o,
  output logic                       blk_o,
  output logic                       unblk_o,
  output logic [LINE_W-1:0]          cmd_line_o,
  output logic [NUM_RESV-1:0]        resv_valid_o,
  output logic [NUM_RESV*LINE_W-1:0] resv_line_o,
  output logic [NUM_RESV*ID_W-1:0]   resv_owner_o
);
  import llsc_pkg::*;

  localparam int AGE_W = (NUM_RESV > 1) ? $clog2(NUM_RESV) : 1;

  cpl_kind_e         kind;
  logic              ent_valid [NUM_RESV];
  logic [LINE_W-1:0] ent_line  [NUM_RESV];
  logic [ID_W-1:0]   ent_owner [NUM_RESV];
  logic [AGE_W-1:0]  ent_age   [NUM_RESV];
  logic [NUM_RESV-1:0] line_hit, own_hit, tgt_sel, clr_sel;
  logic any_line_hit, any_own_hit;

  // Named internal events, visible to the bound checker.
  logic mon_on, ev_ll, ev_sc, ev_plain_wr, ev_wr_clear, ev_clr, ev_blk, ev_unblk, rsp_ok_d;

  assign kind        = cpl_kind_e'(cpl_kind_i);
  assign mon_on      = cpl_valid_i && !bypass_i;
  assign ev_ll       = mon_on && (kind == K_LL);
  assign ev_sc       = mon_on && (kind == K_SC);
  assign ev_plain_wr = mon_on && is_plain_write(kind);
  assign ev_wr_clear = ev_plain_wr && cpl_tag_hit_i && any_own_hit;
  assign ev_clr      = (ev_sc && any_line_hit) || ev_wr_clear;
  assign clr_sel     = ev_sc ? line_hit : own_hit;
  assign ev_blk      = cpl_valid_i && (kind == K_LRMW_RD);
  assign ev_unblk    = cpl_valid_i && (kind == K_LRMW_WR);
  assign rsp_ok_d    = calc_ok(kind, bypass_i, any_own_hit);

  resv_match #(.N(NUM_RESV), .LINE_W(LINE_W), .ID_W(ID_W)) u_match (
    .ent_valid    (ent_valid),
    .ent_line     (ent_line),
    .ent_owner    (ent_owner),
    .q_line       (cpl_line_i),
    .q_id         (cpl_req_id_i),
    .line_hit     (line_hit),
    .own_hit      (own_hit),
    .any_line_hit (any_line_hit),
    .any_own_hit  (any_own_hit)
  );

  resv_victim #(.N(NUM_RESV), .AGE_W(AGE_W)) u_victim (
    .ent_valid (ent_valid),
    .ent_age   (ent_age),
    .line_hit  (line_hit),
    .tgt_sel   (tgt_sel)
  );

  resv_store #(.N(NUM_RESV), .LINE_W(LINE_W), .ID_W(ID_W), .AGE_W(AGE_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ev_ll),
    .wr_sel    (tgt_sel),
    .wr_line   (cpl_line_i),
    .wr_owner  (cpl_req_id_i),
    .clr_en    (ev_clr),
    .clr_sel   (clr_sel),
    .ent_valid (ent_valid),
    .ent_line  (ent_line),
    .ent_owner (ent_owner),
    .ent_age   (ent_age)
  );

  resp_stage #(.LINE_W(LINE_W)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_done  (cpl_valid_i),
    .in_ok    (rsp_ok_d),
    .in_blk   (ev_blk),
    .in_unblk (ev_unblk),
    .in_line  (cpl_line_i),
    .done_q   (rsp_done_o),
    .ok_q     (rsp_ok_o),
    .blk_q    (blk_o),
    .unblk_q  (unblk_o),
    .line_q   (cmd_line_o)
  );

  for (genvar g = 0; g < NUM_RESV; g++) begin : g_flat
    assign resv_valid_o[g]                      = ent_valid[g];
    assign resv_line_o[g*LINE_W +: LINE_W]      = ent_line[g];
    assign resv_owner_o[g*ID_W +: ID_W]         = ent_owner[g];
  end

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
  parameter int NUM_RESV = 4,
  parameter int LINE_W   = 26,
  parameter int ID_W     = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bypass_i,
  input logic                       cpl_valid_i,
  input logic [2:0]                 cpl_kind_i,
  input logic [LINE_W-1:0]          cpl_line_i,
  input logic [ID_W-1:0]            cpl_req_id_i,
  input logic                       rsp_done_o,
  input logic                       rsp_ok_o,
  input logic                       blk_o,
  input logic                       unblk_o,
  input logic [LINE_W-1:0]          cmd_line_o,
  input logic [NUM_RESV-1:0]        resv_valid_o,
  input logic [NUM_RESV*LINE_W-1:0] resv_line_o,
  input logic [NUM_RESV*ID_W-1:0]   resv_owner_o,
  input logic                       ev_ll,
  input logic                       ev_sc
);

  function automatic logic has_line(logic [LINE_W-1:0] l);
    logic r = 1'b0;
    for (int i = 0; i < NUM_RESV; i++)
      if (resv_valid_o[i] && resv_line_o[i*LINE_W +: LINE_W] == l) r = 1'b1;
    return r;
  endfunction

  function automatic logic has_pair(logic [LINE_W-1:0] l, logic [ID_W-1:0] o);
    logic r = 1'b0;
    for (int i = 0; i < NUM_RESV; i++)
      if (resv_valid_o[i] && resv_line_o[i*LINE_W +: LINE_W] == l &&
          resv_owner_o[i*ID_W +: ID_W] == o) r = 1'b1;
    return r;
  endfunction

  AST_LL_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ll |=> has_pair($past(cpl_line_i), $past(cpl_req_id_i)));  // R1

  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sc |=> !has_line($past(cpl_line_i)));  // R5

  AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid_i && cpl_kind_i <= 3'd1) |=> rsp_ok_o);  // R7

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_o && unblk_o));  // R8

  AST_BLK_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid_i && cpl_kind_i == 3'd5) |=> (blk_o && cmd_line_o == $past(cpl_line_i)));  // R8

  AST_BYPASS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid_i && bypass_i) |=> ($stable(resv_valid_o) && $stable(resv_line_o) &&
                                   $stable(resv_owner_o) && rsp_ok_o));  // R9

  AST_DONE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid_i |=> rsp_done_o);  // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid_i |=> (!rsp_done_o && !rsp_ok_o && !blk_o && !unblk_o));  // R10

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(
  .NUM_RESV (NUM_RESV),
  .LINE_W   (LINE_W),
  .ID_W     (ID_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bypass_i     (bypass_i),
  .cpl_valid_i  (cpl_valid_i),
  .cpl_kind_i   (cpl_kind_i),
  .cpl_line_i   (cpl_line_i),
  .cpl_req_id_i (cpl_req_id_i),
  .rsp_done_o   (rsp_done_o),
  .rsp_ok_o     (rsp_ok_o),
  .blk_o        (blk_o),
  .unblk_o      (unblk_o),
  .cmd_line_o   (cmd_line_o),
  .resv_valid_o (resv_valid_o),
  .resv_line_o  (resv_line_o),
  .resv_owner_o (resv_owner_o),
  .ev_ll        (ev_ll),
  .ev_sc        (ev_sc)
);

// File: tb/tb_llsc_resv_monitor.sv
`timescale 1ns/1ps
module tb_llsc_resv_monitor;
  localparam int NR = 4;
  localparam int LW = 26;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bypass = 1'b0, cvalid = 1'b0, chit = 1'b0;
  logic [2:0] ckind = '0;
  logic [LW-1:0] cline = '0;
  logic [IW-1:0] cid = '0;
  logic done, ok, blk, unblk;
  logic [LW-1:0] cmd_line;
  logic [NR-1:0] rvalid;
  logic [NR*LW-1:0] rline;
  logic [NR*IW-1:0] rowner;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  llsc_resv_monitor #(.NUM_RESV(NR), .LINE_W(LW), .ID_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .bypass_i(bypass), .cpl_valid_i(cvalid),
    .cpl_kind_i(ckind), .cpl_line_i(cline), .cpl_req_id_i(cid), .cpl_tag_hit_i(chit),
    .rsp_done_o(done), .rsp_ok_o(ok), .blk_o(blk), .unblk_o(unblk), .cmd_line_o(cmd_line),
    .resv_valid_o(rvalid), .resv_line_o(rline), .resv_owner_o(rowner)
  );

  // Vector: [19] bypass [18:16] kind [15:8] line [7:4] id [3] tag hit
  //         [2] expected ok [1] expected block [0] expected unblock
  localparam int NV = 30;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,3'd3,8'h10,4'd1,1'b1,3'b100},  // R1 linked load
    {1'b0,3'd4,8'h10,4'd1,1'b1,3'b100},  // R4 owner SC passes
    {1'b0,3'd4,8'h10,4'd1,1'b1,3'b000},  // R5 cleared by previous SC
    {1'b0,3'd3,8'h20,4'd2,1'b1,3'b100},
    {1'b0,3'd4,8'h20,4'd3,1'b1,3'b000},  // R4 wrong owner fails
    {1'b0,3'd4,8'h20,4'd2,1'b1,3'b000},  // R5 failed SC also cleared
    {1'b0,3'd3,8'h30,4'd1,1'b1,3'b100},
    {1'b0,3'd0,8'h30,4'd1,1'b1,3'b100},  // R7 load
    {1'b0,3'd1,8'h30,4'd2,1'b1,3'b100},  // R7 fetch
    {1'b0,3'd4,8'h30,4'd1,1'b1,3'b100},  // R7 untouched
    {1'b0,3'd3,8'h40,4'd1,1'b1,3'b100},
    {1'b0,3'd2,8'h40,4'd2,1'b1,3'b100},  // R6 other owner store
    {1'b0,3'd2,8'h40,4'd1,1'b0,3'b100},  // R6 tag absent
    {1'b0,3'd4,8'h40,4'd1,1'b1,3'b100},  // R6 survived
    {1'b0,3'd3,8'h50,4'd1,1'b1,3'b100},
    {1'b0,3'd2,8'h50,4'd1,1'b1,3'b100},  // R6 owner store clears
    {1'b0,3'd4,8'h50,4'd1,1'b1,3'b000},
    {1'b0,3'd5,8'h60,4'd1,1'b1,3'b110},  // R8 block
    {1'b0,3'd6,8'h60,4'd1,1'b1,3'b101},  // R8 unblock
    {1'b0,3'd3,8'h70,4'd3,1'b1,3'b100},
    {1'b1,3'd4,8'h70,4'd4,1'b1,3'b100},  // R9 bypass SC passes
    {1'b1,3'd4,8'h70,4'd3,1'b1,3'b100},  // R9
    {1'b0,3'd4,8'h70,4'd3,1'b1,3'b100},  // R9 reservation untouched
    {1'b1,3'd5,8'h71,4'd1,1'b1,3'b110},  // R8 block under bypass
    {1'b0,3'd3,8'h80,4'd2,1'b1,3'b100},
    {1'b0,3'd3,8'h80,4'd5,1'b1,3'b100},  // R2 rewrite owner
    {1'b0,3'd4,8'h80,4'd5,1'b1,3'b100},  // R2 new owner wins
    {1'b0,3'd3,8'h90,4'd1,1'b1,3'b100},
    {1'b0,3'd7,8'h90,4'd1,1'b1,3'b100},  // R6 atomic clears
    {1'b0,3'd4,8'h90,4'd1,1'b1,3'b000}
  };

  task automatic check(input logic c, input string tag, input int act, input int exp);
    n_chk++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic apply(input logic b, input logic [2:0] k, input int l, input int id, input logic h);
    bypass = b; ckind = k; cline = LW'(l); cid = IW'(id); chit = h; cvalid = 1'b1;
    @(negedge clk);
    cvalid = 1'b0; bypass = 1'b0;
  endtask

  function automatic int slot_of(input int l);
    for (int i = 0; i < NR; i++)
      if (rvalid[i] && rline[i*LW +: LW] == LW'(l)) return i;
    return -1;
  endfunction

  function automatic int count_line(input int l);
    int c = 0;
    for (int i = 0; i < NR; i++)
      if (rvalid[i] && rline[i*LW +: LW] == LW'(l)) c++;
    return c;
  endfunction

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rvalid == '0 && !done && !ok && !blk && !unblk, "R11 reset", int'(rvalid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][19], VEC[v][18:16], int'(VEC[v][15:8]), int'(VEC[v][7:4]), VEC[v][3]);
      check(done, $sformatf("R10 done vec%0d", v), int'(done), 1);
      check(ok == VEC[v][2], $sformatf("R4/R6/R7/R9 ok vec%0d", v), int'(ok), int'(VEC[v][2]));
      check(blk == VEC[v][1] && unblk == VEC[v][0], $sformatf("R8 pulses vec%0d", v),
            int'({blk, unblk}), int'(VEC[v][1:0]));
      if (VEC[v][1] || VEC[v][0])
        check(cmd_line == LW'(VEC[v][15:8]), $sformatf("R8 line vec%0d", v),
              int'(cmd_line), int'(VEC[v][15:8]));
    end

    // R10 idle cycle: nothing asserted
    @(negedge clk);
    check(!done && !ok && !blk && !unblk, "R10 idle", int'({done, ok, blk, unblk}), 0);
    check(rvalid == '0, "R5/R6 table empty after vectors", int'(rvalid), 0);

    // R1 / R2 in place rewrite
    apply(1'b0, 3'd3, 'hA0, 1, 1'b1);
    apply(1'b0, 3'd3, 'hA0, 2, 1'b1);
    check(count_line('hA0) == 1, "R2 single register", count_line('hA0), 1);
    check(slot_of('hA0) == 0 && rowner[0 +: IW] == IW'(2), "R2 owner rewritten",
          int'(rowner[0 +: IW]), 2);
    apply(1'b0, 3'd4, 'hA0, 2, 1'b1);

    // R3 fill, replacement order, reuse of freed register
    apply(1'b0, 3'd3, 'hB1, 1, 1'b1);
    apply(1'b0, 3'd3, 'hB2, 1, 1'b1);
    apply(1'b0, 3'd3, 'hB3, 1, 1'b1);
    apply(1'b0, 3'd3, 'hB4, 1, 1'b1);
    check(slot_of('hB1) == 0 && slot_of('hB4) == 3, "R3 lowest free order", slot_of('hB4), 3);
    apply(1'b0, 3'd3, 'hB5, 1, 1'b1);
    check(slot_of('hB5) == 0 && slot_of('hB1) == -1, "R3 oldest replaced", slot_of('hB5), 0);
    apply(1'b0, 3'd3, 'hB2, 1, 1'b1);   // refresh register 1
    apply(1'b0, 3'd3, 'hB6, 1, 1'b1);
    check(slot_of('hB6) == 2 && slot_of('hB2) == 1, "R3 refresh counts as write", slot_of('hB6), 2);
    apply(1'b0, 3'd4, 'hB4, 1, 1'b1);
    check(ok && slot_of('hB4) == -1, "R5 SC frees register 3", slot_of('hB4), -1);
    apply(1'b0, 3'd3, 'hB7, 1, 1'b1);
    check(slot_of('hB7) == 3, "R3 freed register reused", slot_of('hB7), 3);

    // R8 + R6 same cycle: locked write unblocks and drops owned reservation
    apply(1'b0, 3'd3, 'hC0, 4, 1'b1);   // replaces oldest (B5, register 0)
    check(slot_of('hC0) == 0, "R3 oldest after reuse", slot_of('hC0), 0);
    apply(1'b0, 3'd6, 'hC0, 4, 1'b1);
    check(unblk && !blk && cmd_line == LW'('hC0), "R8 unblock with clear", int'(unblk), 1);
    check(slot_of('hC0) == -1, "R6 locked write clears owned line", slot_of('hC0), -1);

    // R11 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check(rvalid == '0 && !done, "R11 reset clears", int'(rvalid), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule